// File: doc/BRIEF.md
# Eight-Point Weave Column Transform

This block computes a complete 8-point complex DFT on every clock cycle. It is used as the column stage of a two-dimensional long transform. A frame of 8×N samples sits in one half of a double buffer, and each half is split into eight memories. Once the whole frame is present, the eight memories are read in parallel, so one column of eight complex samples enters the block on each clock. N such columns stream through back to back. All eight bins of a column leave the block together, a fixed number of cycles later.

The arithmetic is arranged as a weave. Three stages of additions and subtractions come first, and multiplications by ±j are folded into these as swaps of the real and imaginary parts. One stage then multiplies two intermediate values by a single Q1.15 constant. A last addition stage forms the odd bins. Every addition stage widens the word by one bit. The final results are divided by eight with rounding and saturated to 16 bits. A valid flag travels alongside the data, so a frame of N columns is done N−1+5 cycles after its first column enters.

The block does not apply twiddle correction between the row stage and the column stage. That correction is the responsibility of the logic that surrounds it.

Top module: `wdft_top`

## Requirements
- R1: For input column x[n] (n = 0..7, lane n of `in_re`/`in_im`), output lane k carries X[k] = Σ x[n]·e^(−j2πnk/8) divided by 8, rounded, within 3 LSB of the exact value when no saturation applies.
- R2: The result for a column sampled at clock edge t appears on the outputs after edge t+4. The latency is 5 register stages.
- R3: `out_valid` equals `in_valid` delayed by exactly 5 cycles, and columns may be presented on every cycle with no gaps, giving one transform per cycle.
- R4: While `rst` is high at a clock edge, `out_valid` is low after that edge. After reset is released, `out_valid` stays low until a valid column has passed the 5 stages.
- R5: A scaled result above 32767 is output as 32767, and one below −32768 is output as −32768, on the real and the imaginary part separately.
- R6: A constant input column (all eight lanes equal) produces exactly that value in bin 0 and exactly zero in bins 1..7.
- R7: A column with x[n] = x[n+4] for n = 0..3 produces exactly zero in every odd bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks the current input column as valid |
| in_re | input | 8×16 | Real parts of the column, lane n = sample n, signed |
| in_im | input | 8×16 | Imaginary parts of the column, lane n = sample n, signed |
| out_valid | output | 1 | Marks the current output column as valid |
| out_re | output | 8×16 | Real parts of the scaled bins, lane k = bin k, signed |
| out_im | output | 8×16 | Imaginary parts of the scaled bins, lane k = bin k, signed |

## Verification
Some properties are checked by assertions on every cycle. The valid flag is tied to `in_valid` five edges earlier and is cleared by reset. The bin-0 real sum after the pre-weave stages is compared with the sum of the real input lanes three cycles before. The constant multiplier is checked never to increase a magnitude. When all odd-path terms are zero, the odd bins must come out as zero. Other behaviours only show up in the bench scenarios against a floating-point DFT. These are the exact values of every bin, the alignment of each result to its own column under a stream with gaps, the rounding of the divide-by-eight, and saturation at both signs.

// File: rtl/wdft_pkg.sv
`timescale 1ns/1ps
package wdft_pkg;
    localparam int PTS       = 8;
    localparam int HALF      = PTS / 2;
    localparam int LOG2_PTS  = $clog2(PTS);
    localparam int SMP_W     = 16;
    localparam int COEF_FRAC = 15;
    localparam int COEF_W    = COEF_FRAC + 1;
    localparam int W1        = SMP_W + 1;
    localparam int W2        = SMP_W + 2;
    localparam int W3        = SMP_W + 3;
    localparam int W5        = SMP_W + 4;
    localparam int PW        = W3 + COEF_W;
    localparam int LAT       = 5;

    // cos(pi/4) in Q1.15
    localparam logic signed [COEF_W-1:0] ROT_COEF = 16'sd23170;
    localparam logic signed [PW-1:0]     MUL_RND  = PW'(1 << (COEF_FRAC - 1));
    localparam logic signed [W5-1:0]     SCL_RND  = W5'(PTS / 2);
    localparam logic signed [W5-1:0]     SAT_HI   = W5'((1 << (SMP_W - 1)) - 1);
    localparam logic signed [W5-1:0]     SAT_LO   = -W5'(1 << (SMP_W - 1));

    typedef struct packed { logic signed [SMP_W-1:0] re; logic signed [SMP_W-1:0] im; } smp_t;
    typedef struct packed { logic signed [W1-1:0] re; logic signed [W1-1:0] im; } cx1_t;
    typedef struct packed { logic signed [W2-1:0] re; logic signed [W2-1:0] im; } cx2_t;
    typedef struct packed { logic signed [W3-1:0] re; logic signed [W3-1:0] im; } cx3_t;
    typedef struct packed { logic signed [W5-1:0] re; logic signed [W5-1:0] im; } cx5_t;

    // evn[k] holds bin 2k; p/q feed odd bins; ru/rv are the rotation operands
    typedef struct packed {
        cx3_t [HALF-1:0] evn;
        cx3_t            p;
        cx3_t            q;
        cx3_t            ru;
        cx3_t            rv;
    } weave_t;

    function automatic logic signed [W3-1:0] rot_mul(input logic signed [W3-1:0] s);
        logic signed [PW-1:0] prod;
        prod = PW'(s) * PW'(ROT_COEF);
        prod = prod + MUL_RND;
        prod = prod >>> COEF_FRAC;
        return prod[W3-1:0];
    endfunction

    function automatic logic signed [SMP_W-1:0] scale_sat(input logic signed [W5-1:0] v);
        logic signed [W5-1:0] t;
        t = (v + SCL_RND) >>> LOG2_PTS;
        if (t > SAT_HI)      return SAT_HI[SMP_W-1:0];
        else if (t < SAT_LO) return SAT_LO[SMP_W-1:0];
        else                 return t[SMP_W-1:0];
    endfunction

    function automatic logic [W3-1:0] mag3(input logic signed [W3-1:0] v);
        return (v < 0) ? -v : v;
    endfunction
endpackage

// File: rtl/wdft_preadd.sv
`timescale 1ns/1ps
module wdft_preadd
    import wdft_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  smp_t [PTS-1:0]       x,
    output weave_t               mid
);
    cx1_t [HALF-1:0] sum_q, dif_q;
    cx2_t c0_q, c1_q, d0_q, d1_q, p_q, q_q, u_q, v_q;

    // stage 1: butterflies across the two halves
    always_ff @(posedge clk) begin
        for (int n = 0; n < HALF; n++) begin
            sum_q[n].re <= W1'(x[n].re) + W1'(x[n+HALF].re);
            sum_q[n].im <= W1'(x[n].im) + W1'(x[n+HALF].im);
            dif_q[n].re <= W1'(x[n].re) - W1'(x[n+HALF].re);
            dif_q[n].im <= W1'(x[n].im) - W1'(x[n+HALF].im);
        end
    end

    // stage 2: second butterfly level, -j and +j folded as swaps
    always_ff @(posedge clk) begin
        c0_q.re <= W2'(sum_q[0].re) + W2'(sum_q[2].re);
        c0_q.im <= W2'(sum_q[0].im) + W2'(sum_q[2].im);
        c1_q.re <= W2'(sum_q[0].re) - W2'(sum_q[2].re);
        c1_q.im <= W2'(sum_q[0].im) - W2'(sum_q[2].im);
        d0_q.re <= W2'(sum_q[1].re) + W2'(sum_q[3].re);
        d0_q.im <= W2'(sum_q[1].im) + W2'(sum_q[3].im);
        d1_q.re <= W2'(sum_q[1].re) - W2'(sum_q[3].re);
        d1_q.im <= W2'(sum_q[1].im) - W2'(sum_q[3].im);
        p_q.re  <= W2'(dif_q[0].re) + W2'(dif_q[2].im);
        p_q.im  <= W2'(dif_q[0].im) - W2'(dif_q[2].re);
        q_q.re  <= W2'(dif_q[0].re) - W2'(dif_q[2].im);
        q_q.im  <= W2'(dif_q[0].im) + W2'(dif_q[2].re);
        u_q.re  <= W2'(dif_q[1].re) + W2'(dif_q[3].im);
        u_q.im  <= W2'(dif_q[1].im) - W2'(dif_q[3].re);
        v_q.re  <= W2'(dif_q[1].re) - W2'(dif_q[3].im);
        v_q.im  <= W2'(dif_q[1].im) + W2'(dif_q[3].re);
    end

    // stage 3: even bins complete, rotation operands prepared
    always_ff @(posedge clk) begin
        mid.evn[0].re <= W3'(c0_q.re) + W3'(d0_q.re);
        mid.evn[0].im <= W3'(c0_q.im) + W3'(d0_q.im);
        mid.evn[2].re <= W3'(c0_q.re) - W3'(d0_q.re);
        mid.evn[2].im <= W3'(c0_q.im) - W3'(d0_q.im);
        mid.evn[1].re <= W3'(c1_q.re) + W3'(d1_q.im);
        mid.evn[1].im <= W3'(c1_q.im) - W3'(d1_q.re);
        mid.evn[3].re <= W3'(c1_q.re) - W3'(d1_q.im);
        mid.evn[3].im <= W3'(c1_q.im) + W3'(d1_q.re);
        mid.p.re      <= W3'(p_q.re);
        mid.p.im      <= W3'(p_q.im);
        mid.q.re      <= W3'(q_q.re);
        mid.q.im      <= W3'(q_q.im);
        mid.ru.re     <= W3'(u_q.re) + W3'(u_q.im);
        mid.ru.im     <= W3'(u_q.im) - W3'(u_q.re);
        mid.rv.re     <= W3'(v_q.re) + W3'(v_q.im);
        mid.rv.im     <= W3'(v_q.im) - W3'(v_q.re);
    end

    // ---- checking ----
    logic [1:0]            age;
    logic signed [W3-1:0]  in_sum_re;

    always_ff @(posedge clk) begin
        if (rst)             age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    always_comb begin
        in_sum_re = '0;
        for (int n = 0; n < PTS; n++) in_sum_re = in_sum_re + W3'(x[n].re);
    end

    assert_dc_bin_R6: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (mid.evn[0].re == $past(in_sum_re, 3)));
endmodule

// File: rtl/wdft_rotmul.sv
`timescale 1ns/1ps
module wdft_rotmul
    import wdft_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  weave_t mid,
    output weave_t prd
);
    // the single point-wise constant multiply stage
    always_ff @(posedge clk) begin
        prd.evn   <= mid.evn;
        prd.p     <= mid.p;
        prd.q     <= mid.q;
        prd.ru.re <= rot_mul(mid.ru.re);
        prd.ru.im <= rot_mul(mid.ru.im);
        prd.rv.re <= rot_mul(mid.rv.re);
        prd.rv.im <= rot_mul(mid.rv.im);
    end

    logic warm;
    always_ff @(posedge clk) begin
        if (rst) warm <= 1'b0;
        else     warm <= 1'b1;
    end

    assert_rot_shrink_R1: assert property (@(posedge clk) disable iff (rst)
        warm |-> (mag3(prd.ru.re) <= mag3($past(mid.ru.re)) &&
                  mag3(prd.rv.im) <= mag3($past(mid.rv.im))));
endmodule

// File: rtl/wdft_postadd.sv
`timescale 1ns/1ps
module wdft_postadd
    import wdft_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  weave_t         prd,
    output smp_t [PTS-1:0] y
);
    cx5_t [PTS-1:0] full;

    always_comb begin
        for (int k = 0; k < HALF; k++) begin
            full[2*k].re = W5'(prd.evn[k].re);
            full[2*k].im = W5'(prd.evn[k].im);
        end
        full[1].re = W5'(prd.p.re) + W5'(prd.ru.re);
        full[1].im = W5'(prd.p.im) + W5'(prd.ru.im);
        full[5].re = W5'(prd.p.re) - W5'(prd.ru.re);
        full[5].im = W5'(prd.p.im) - W5'(prd.ru.im);
        full[3].re = W5'(prd.q.re) + W5'(prd.rv.im);
        full[3].im = W5'(prd.q.im) - W5'(prd.rv.re);
        full[7].re = W5'(prd.q.re) - W5'(prd.rv.im);
        full[7].im = W5'(prd.q.im) + W5'(prd.rv.re);
    end

    for (genvar k = 0; k < PTS; k++) begin : g_scale
        always_ff @(posedge clk) begin
            y[k].re <= scale_sat(full[k].re);
            y[k].im <= scale_sat(full[k].im);
        end
    end

    logic warm;
    always_ff @(posedge clk) begin
        if (rst) warm <= 1'b0;
        else     warm <= 1'b1;
    end

    assert_odd_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(prd.p == '0 && prd.q == '0 && prd.ru == '0 && prd.rv == '0))
        |-> (y[1] == '0 && y[3] == '0 && y[5] == '0 && y[7] == '0));
endmodule

// File: rtl/wdft_top.sv
`timescale 1ns/1ps
module wdft_top
    import wdft_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [PTS-1:0][SMP_W-1:0]   in_re,
    input  logic [PTS-1:0][SMP_W-1:0]   in_im,
    output logic                        out_valid,
    output logic [PTS-1:0][SMP_W-1:0]   out_re,
    output logic [PTS-1:0][SMP_W-1:0]   out_im
);
    smp_t [PTS-1:0] col_in;
    smp_t [PTS-1:0] col_out;
    weave_t         mid;
    weave_t         prd;
    logic [LAT-1:0] vld_sr;

    for (genvar n = 0; n < PTS; n++) begin : g_lanes
        assign col_in[n].re = in_re[n];
        assign col_in[n].im = in_im[n];
        assign out_re[n]    = col_out[n].re;
        assign out_im[n]    = col_out[n].im;
    end

    wdft_preadd  u_pre  (.clk(clk), .rst(rst), .x(col_in), .mid(mid));
    wdft_rotmul  u_mul  (.clk(clk), .rst(rst), .mid(mid), .prd(prd));
    wdft_postadd u_post (.clk(clk), .rst(rst), .prd(prd), .y(col_out));

    always_ff @(posedge clk) begin
        if (rst) vld_sr <= '0;
        else     vld_sr <= {vld_sr[LAT-2:0], in_valid};
    end
    assign out_valid = vld_sr[LAT-1];

    assert_valid_rise_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##LAT out_valid);
    assert_valid_low_R3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##LAT !out_valid);
    assert_reset_clear_R4: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

// File: tb/tb_wdft_top.sv
`timescale 1ns/1ps
module tb_wdft_top;
    localparam int NP    = 8;
    localparam int LATC  = 5;
    localparam int NV    = 220;
    localparam int NS    = 260;
    localparam int TOL   = 3;
    localparam real PI   = 3.14159265358979;

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic [NP-1:0][15:0] in_re, in_im;
    logic out_valid;
    logic [NP-1:0][15:0] out_re, out_im;

    int vre [NV][NP];
    int vim [NV][NP];
    int sched [NS];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdft_top dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
                  .out_valid(out_valid), .out_re(out_re), .out_im(out_im));

    task automatic chk(input string req, input string what, input int got, input int exp, input int tol);
        int d;
        n_chk++;
        d = got - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int ref_bin(input int idx, input int k, input bit want_im);
        real sr, si, ang, v;
        int e;
        sr = 0.0; si = 0.0;
        for (int n = 0; n < NP; n++) begin
            ang = 2.0 * PI * real'(n * k) / real'(NP);
            sr = sr + real'(vre[idx][n]) * $cos(ang) + real'(vim[idx][n]) * $sin(ang);
            si = si + real'(vim[idx][n]) * $cos(ang) - real'(vre[idx][n]) * $sin(ang);
        end
        v = (want_im ? si : sr) / real'(NP);
        e = $rtoi($floor(v + 0.5));
        if (e > 32767) e = 32767;
        if (e < -32768) e = -32768;
        return e;
    endfunction

    task automatic drive(input int idx);
        for (int n = 0; n < NP; n++) begin
            in_re[n] = vre[idx][n][15:0];
            in_im[n] = vim[idx][n][15:0];
        end
    endtask

    task automatic check_step(input int s);
        int idx;
        string tag;
        idx = (s >= LATC) ? sched[s-LATC] : -1;
        chk((s < 2*LATC) ? "R4" : "R3", "out_valid", int'(out_valid), (idx >= 0) ? 1 : 0, 0);
        if (idx >= 0) begin
            if (idx < 8)                       tag = "R2";
            else if (idx == 16)                tag = "R6";
            else if (idx == 17)                tag = "R7";
            else if (idx == 18 || idx == 19)   tag = "R5";
            else                               tag = "R1";
            for (int k = 0; k < NP; k++) begin
                int er, ei, tl;
                er = ref_bin(idx, k, 1'b0);
                ei = ref_bin(idx, k, 1'b1);
                tl = (idx == 16 || (idx == 17 && k % 2 == 1)) ? 0 : TOL;
                chk(tag, $sformatf("vec %0d bin %0d re", idx, k), int'($signed(out_re[k])), er, tl);
                chk(tag, $sformatf("vec %0d bin %0d im", idx, k), int'($signed(out_im[k])), ei, tl);
            end
            if (idx == 18) chk("R5", "positive clamp", int'($signed(out_re[1])), 32767, 0);
            if (idx == 19) chk("R5", "negative clamp", int'($signed(out_re[1])), -32768, 0);
        end
    endtask

    initial begin
        int unsigned lcg;
        int vi;
        real c, sn;
        lcg = 32'h1234_5678;
        for (int i = 0; i < 8; i++)
            for (int n = 0; n < NP; n++) begin
                vre[i][n] = (n == i) ? 12000 : 0;
                vim[i][n] = (n == i) ? -7000 : 0;
            end
        for (int m = 0; m < 8; m++)
            for (int n = 0; n < NP; n++) begin
                vre[8+m][n] = $rtoi($floor(8000.0 * $cos(2.0 * PI * real'(m * n) / 8.0) + 0.5));
                vim[8+m][n] = $rtoi($floor(8000.0 * $sin(2.0 * PI * real'(m * n) / 8.0) + 0.5));
            end
        for (int n = 0; n < NP; n++) begin
            vre[16][n] = 1234;
            vim[16][n] = -4321;
        end
        for (int n = 0; n < NP/2; n++) begin
            lcg = lcg * 1103515245 + 12345;
            vre[17][n] = int'((lcg >> 16) & 32'hffff) - 32768;
            lcg = lcg * 1103515245 + 12345;
            vim[17][n] = int'((lcg >> 16) & 32'hffff) - 32768;
            vre[17][n+4] = vre[17][n];
            vim[17][n+4] = vim[17][n];
        end
        for (int n = 0; n < NP; n++) begin
            c  = $cos(2.0 * PI * real'(n) / 8.0);
            sn = $sin(2.0 * PI * real'(n) / 8.0);
            vre[18][n] = (c > 0.1) ? 32767 : ((c < -0.1) ? -32767 : 0);
            vim[18][n] = (sn > 0.1) ? 32767 : ((sn < -0.1) ? -32767 : 0);
            vre[19][n] = -vre[18][n];
            vim[19][n] = -vim[18][n];
        end
        for (int i = 20; i < NV; i++)
            for (int n = 0; n < NP; n++) begin
                lcg = lcg * 1103515245 + 12345;
                vre[i][n] = int'((lcg >> 16) & 32'hffff) - 32768;
                lcg = lcg * 1103515245 + 12345;
                vim[i][n] = int'((lcg >> 16) & 32'hffff) - 32768;
            end

        vi = 0;
        for (int s = 0; s < NS; s++) begin
            if (s % 9 == 8 || vi >= NV) sched[s] = -1;
            else begin
                sched[s] = vi;
                vi++;
            end
        end

        rst = 1'b1;
        in_valid = 1'b1;
        drive(5);
        repeat (4) begin
            @(negedge clk);
            chk("R4", "out_valid in reset", int'(out_valid), 0, 0);
        end
        @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < NS; s++) begin
            if (s > 0) @(negedge clk);
            check_step(s);
            if (sched[s] >= 0) begin
                in_valid = 1'b1;
                drive(sched[s]);
            end else begin
                in_valid = 1'b0;
                drive((s * 7) % NV);
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule